// File: doc/BRIEF.md
# Power-Up Strap Latch Controller

This block sits beside the pad ring of a clock generator and turns a handful of configuration straps into stable mode signals. Until the power-good strobe arrives, the frequency-select pins and the multiplexed strap pins are inputs. The block follows their levels. The strobe's first synchronized rising edge freezes the strap values. The multiplexed pins then become clock outputs, and the strobe pin itself is reused as a live active-low power-down input.

The frozen values give several results:
- a CPU frequency code, with a safe fallback for the reserved combination and an error flag;
- a test-mode flag and the choice of test behaviour;
- the role of the debug-port pair and of the graphics pairs;
- one output-enable per multiplexed pin.

All pad inputs cross through reset-to-zero synchronizers. An undriven graphics-select strap, held low by its pad pull-down, therefore also reads 0 straight after reset.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While reset is held, and afterwards until the first latch event, latched_o, pd_req_o, test_mode_o, test_ref_o and every bit of pin_oe_o are 0.
- R2: Before the latch event, cpu_code_o, itp_cpu_o and gfx_alt_o follow the strap pins. A level present at the pins at one rising clock edge is visible on the outputs after the second edge that follows it.
- R3: A high strobe level present at one rising edge sets latched_o after the second edge that follows it. From then on, changes at the strap pins have no effect on any output derived from them.
- R4: cpu_code_o equals the strap bits ordered {fs_c_i, fs_b_i, fs_a_i}. The codes mean 000=266.6, 001=133.3, 010=200.0, 011=166.6, 100=333.3, 101=100.0 and 110=400.0 MHz.
- R5: The reserved code 111 drives cpu_code_o to 101 (100 MHz) and sets cfg_err_o. For every other code cfg_err_o is 0.
- R6: After latching, test_mode_o equals the latched test-select strap. In test mode, test_ref_o equals the latched fs_b_i strap (1 = outputs carry the reference clock, 0 = high impedance). With fs_b_i at 0 in test mode, every pin_oe_o bit is 0.
- R7: After latching outside test mode, or in test mode with reference output, every pin_oe_o bit is 1. Bit 0 is the shared test-select pin, which then drives the 14.318 MHz reference.
- R8: itp_cpu_o equals the debug-port strap (1 = the pair runs as an extra CPU clock, 0 = as an SRC clock).
- R9: gfx_alt_o equals the graphics strap (0 = dot-96 and LCD clocks, 1 = SRC and 27 MHz plain/spread clocks).
- R10: After latching, pd_req_o is the inverse of the strobe pin. A level at one rising edge is reflected after the following edge.
- R11: Taking the strobe low and then high again after latching does not re-sample the straps; latched_o stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pg_strobe_i | input | 1 | Power-good strobe, later the active-low power-down pin |
| test_sel_i | input | 1 | Test-select strap |
| fs_c_i | input | 1 | Frequency-select bit C (MSB) |
| fs_b_i | input | 1 | Frequency-select bit B, also the test behaviour choice |
| fs_a_i | input | 1 | Frequency-select bit A (LSB) |
| itp_en_i | input | 1 | Debug-port pair enable strap |
| gfx_sel_i | input | 1 | Graphics clock select strap |
| latched_o | output | 1 | Straps frozen |
| cpu_code_o | output | 3 | Decoded CPU frequency code |
| cfg_err_o | output | 1 | Reserved frequency code seen |
| test_mode_o | output | 1 | Test mode active |
| test_ref_o | output | 1 | Test mode drives the reference clock |
| itp_cpu_o | output | 1 | Debug pair acts as a CPU clock |
| gfx_alt_o | output | 1 | Graphics pairs in alternate assignment |
| pd_req_o | output | 1 | Power-down request |
| pin_oe_o | output | N_MUX_PINS | Output enable per multiplexed strap pin |

## Verification
Strap-derived outputs follow a pin change after the second rising edge that follows it, that is two synchronizer stages plus the capture register. The latch flag has the same delay after the strobe is raised. The power-down request follows the strobe pin after only one following edge, because it uses the synchronizer output directly. The bench drives its inputs at falling edges. It counts posedges exactly, samples at the next falling edge, and also checks that latched_o is still 0 one edge early. Strap changes after latching are held for several cycles before the frozen values are compared, so a late capture would show up.

// File: rtl/strap_latch_pkg.sv
package strap_latch_pkg;
  typedef struct packed {
    logic test_sel;
    logic fs_c;
    logic fs_b;
    logic fs_a;
    logic itp_en;
    logic gfx_sel;
  } straps_t;

  localparam int STRAP_W = $bits(straps_t);
  localparam logic [2:0] FS_RESERVED = 3'b111;
  localparam logic [2:0] FS_FALLBACK = 3'b101;

  function automatic logic [2:0] map_fs(input logic [2:0] raw);
    return (raw == FS_RESERVED) ? FS_FALLBACK : raw;
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[k] <= '0;
        else         stg[k] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[k] <= '0;
        else         stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_latch_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pg_s_i,
  input  straps_t  straps_s_i,
  output straps_t  shadow_o,
  output logic     latched_o
);
  logic pg_q;
  logic first_rise;

  assign first_rise = pg_s_i & ~pg_q & ~latched_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q      <= 1'b0;
      latched_o <= 1'b0;
      shadow_o  <= '0;
    end else begin
      pg_q <= pg_s_i;
      if (!latched_o) shadow_o <= straps_s_i;
      if (first_rise) latched_o <= 1'b1;
    end
  end
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_latch_pkg::*;
#(
  parameter int N_MUX_PINS = 4
) (
  input  straps_t                 shadow_i,
  input  logic                    latched_i,
  input  logic                    pg_s_i,
  output logic [2:0]              cpu_code_o,
  output logic                    cfg_err_o,
  output logic                    test_mode_o,
  output logic                    test_ref_o,
  output logic                    itp_cpu_o,
  output logic                    gfx_alt_o,
  output logic                    pd_req_o,
  output logic [N_MUX_PINS-1:0]   pin_oe_o
);
  logic [2:0] raw_fs;
  logic       drive_en;

  assign raw_fs      = {shadow_i.fs_c, shadow_i.fs_b, shadow_i.fs_a};
  assign cpu_code_o  = map_fs(raw_fs);
  assign cfg_err_o   = (raw_fs == FS_RESERVED);
  assign test_mode_o = latched_i & shadow_i.test_sel;
  assign test_ref_o  = test_mode_o & shadow_i.fs_b;
  assign itp_cpu_o   = shadow_i.itp_en;
  assign gfx_alt_o   = shadow_i.gfx_sel;
  assign pd_req_o    = latched_i & ~pg_s_i;
  assign drive_en    = latched_i & ~(test_mode_o & ~shadow_i.fs_b);

  for (genvar p = 0; p < N_MUX_PINS; p++) begin : g_pin
    assign pin_oe_o[p] = drive_en;
  end
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
  import strap_latch_pkg::*;
#(
  parameter int N_MUX_PINS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pg_strobe_i,
  input  logic                  test_sel_i,
  input  logic                  fs_c_i,
  input  logic                  fs_b_i,
  input  logic                  fs_a_i,
  input  logic                  itp_en_i,
  input  logic                  gfx_sel_i,
  output logic                  latched_o,
  output logic [2:0]            cpu_code_o,
  output logic                  cfg_err_o,
  output logic                  test_mode_o,
  output logic                  test_ref_o,
  output logic                  itp_cpu_o,
  output logic                  gfx_alt_o,
  output logic                  pd_req_o,
  output logic [N_MUX_PINS-1:0] pin_oe_o
);
  localparam int SYNC_W = STRAP_W + 1;

  logic [SYNC_W-1:0] pad_raw;
  logic [SYNC_W-1:0] pad_s;
  straps_t           straps_s;
  straps_t           shadow;
  logic              pg_s;

  assign pad_raw = {pg_strobe_i, test_sel_i, fs_c_i, fs_b_i, fs_a_i, itp_en_i, gfx_sel_i};
  assign pg_s     = pad_s[SYNC_W-1];
  assign straps_s = straps_t'(pad_s[STRAP_W-1:0]);

  strap_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_raw), .q_o(pad_s)
  );

  strap_capture u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .pg_s_i(pg_s), .straps_s_i(straps_s),
    .shadow_o(shadow), .latched_o(latched_o)
  );

  strap_decode #(.N_MUX_PINS(N_MUX_PINS)) u_dec (
    .shadow_i(shadow), .latched_i(latched_o), .pg_s_i(pg_s),
    .cpu_code_o(cpu_code_o), .cfg_err_o(cfg_err_o), .test_mode_o(test_mode_o),
    .test_ref_o(test_ref_o), .itp_cpu_o(itp_cpu_o), .gfx_alt_o(gfx_alt_o),
    .pd_req_o(pd_req_o), .pin_oe_o(pin_oe_o)
  );
endmodule

// File: rtl/strap_latch_chk.sv
module strap_latch_chk #(
  parameter int N_MUX_PINS = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  latched_o,
  input logic [2:0]            cpu_code_o,
  input logic                  cfg_err_o,
  input logic                  test_mode_o,
  input logic                  test_ref_o,
  input logic                  itp_cpu_o,
  input logic                  gfx_alt_o,
  input logic                  pd_req_o,
  input logic [N_MUX_PINS-1:0] pin_oe_o
);
  AST_LATCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o |=> latched_o); // R11
  AST_FROZEN_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_o && $past(latched_o)) |-> ($stable(cpu_code_o) && $stable(itp_cpu_o) && $stable(gfx_alt_o) && $stable(test_mode_o))); // R3
  AST_NO_RESERVED_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_code_o != 3'b111); // R5
  AST_ERR_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (cpu_code_o == 3'b101)); // R5
  AST_IDLE_BEFORE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latched_o |-> (!pd_req_o && !test_mode_o && (pin_oe_o == '0))); // R1
  AST_PD_ONLY_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_req_o |-> latched_o); // R10
  AST_TEST_REF_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_ref_o |-> test_mode_o); // R6
  AST_HIZ_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_mode_o && !test_ref_o) |-> (pin_oe_o == '0)); // R6
endmodule

bind strap_latch_ctrl strap_latch_chk #(.N_MUX_PINS(N_MUX_PINS)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .latched_o(latched_o), .cpu_code_o(cpu_code_o),
  .cfg_err_o(cfg_err_o), .test_mode_o(test_mode_o), .test_ref_o(test_ref_o),
  .itp_cpu_o(itp_cpu_o), .gfx_alt_o(gfx_alt_o), .pd_req_o(pd_req_o), .pin_oe_o(pin_oe_o)
);

// File: tb/strap_latch_ctrl_tb.sv
module strap_latch_ctrl_tb_top;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b0;
  logic ts = 1'b0, fc = 1'b0, fb = 1'b0, fa = 1'b0, itp = 1'b0, gfx = 1'b0;
  logic          latched, cfg_err, test_mode, test_ref, itp_cpu, gfx_alt, pd_req;
  logic [2:0]    cpu_code;
  logic [NP-1:0] pin_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  strap_latch_ctrl #(.N_MUX_PINS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pg_strobe_i(pg), .test_sel_i(ts),
    .fs_c_i(fc), .fs_b_i(fb), .fs_a_i(fa), .itp_en_i(itp), .gfx_sel_i(gfx),
    .latched_o(latched), .cpu_code_o(cpu_code), .cfg_err_o(cfg_err),
    .test_mode_o(test_mode), .test_ref_o(test_ref), .itp_cpu_o(itp_cpu),
    .gfx_alt_o(gfx_alt), .pd_req_o(pd_req), .pin_oe_o(pin_oe)
  );

  function automatic logic [2:0] exp_code(input logic [2:0] raw);
    return (raw == 3'b111) ? 3'b101 : raw;
  endfunction

  function automatic logic [NP-1:0] exp_oe(input logic lat, input logic tsel, input logic b);
    return (lat && !(tsel && !b)) ? '1 : '0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [5:0] s);
    {ts, fc, fb, fa, itp, gfx} = s;
  endtask

  task automatic trial(input logic [5:0] s);
    logic [2:0] raw;
    raw = s[4:2];
    @(negedge clk);
    rst_n = 1'b0; pg = 1'b0; drive(~s);
    edges(2);
    rst_n = 1'b1;
    drive(s);
    edges(3);
    chk(cpu_code == exp_code(raw), "R2 tracked code", cpu_code, exp_code(raw));
    chk(itp_cpu == s[1] && gfx_alt == s[0], "R2 tracked pair roles", {itp_cpu, gfx_alt}, s[1:0]);
    chk(!latched && !pd_req && !test_mode && pin_oe == '0, "R1 idle before latch",
        {latched, pd_req, test_mode, pin_oe}, 0);
    pg = 1'b1;
    edges(2);
    chk(latched == 1'b0, "R3 latch not early", latched, 0);
    edges(1);
    chk(latched == 1'b1, "R3 latch timing", latched, 1);
    chk(cpu_code == exp_code(raw), "R4 code", cpu_code, exp_code(raw));
    chk(cfg_err == (raw == 3'b111), "R5 err flag", cfg_err, raw == 3'b111);
    chk(test_mode == s[5], "R6 test mode", test_mode, s[5]);
    chk(test_ref == (s[5] & s[3]), "R6 test ref", test_ref, s[5] & s[3]);
    chk(pin_oe == exp_oe(1'b1, s[5], s[3]), "R7 pin oe", pin_oe, exp_oe(1'b1, s[5], s[3]));
    chk(itp_cpu == s[1], "R8 itp role", itp_cpu, s[1]);
    chk(gfx_alt == s[0], "R9 gfx role", gfx_alt, s[0]);
    chk(pd_req == 1'b0, "R10 no pd while high", pd_req, 0);
    drive(~s);
    edges(5);
    chk(cpu_code == exp_code(raw) && itp_cpu == s[1] && gfx_alt == s[0] && test_mode == s[5],
        "R3 frozen", {cpu_code, itp_cpu, gfx_alt, test_mode}, {exp_code(raw), s[1], s[0], s[5]});
    pg = 1'b0;
    edges(1);
    chk(pd_req == 1'b0, "R10 pd not early", pd_req, 0);
    edges(1);
    chk(pd_req == 1'b1, "R10 pd asserted", pd_req, 1);
    pg = 1'b1;
    edges(4);
    chk(pd_req == 1'b0 && latched == 1'b1, "R11 pd released, still latched", {pd_req, latched}, 2'b01);
    chk(cpu_code == exp_code(raw) && cfg_err == (raw == 3'b111) && pin_oe == exp_oe(1'b1, s[5], s[3]),
        "R11 no resample", cpu_code, exp_code(raw));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd2024));
    edges(2);
    chk(!latched && !pd_req && !test_mode && !test_ref && pin_oe == '0, "R1 reset state",
        {latched, pd_req, test_mode, test_ref, pin_oe}, 0);
    for (int i = 0; i < 8; i++) trial({1'b0, i[2:0], 2'b10});
    trial(6'b110000);
    trial(6'b101001);
    trial(6'b111111);
    trial(6'b000000);
    for (int i = 0; i < 40; i++) trial(6'($urandom()));
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule